// File: doc/BRIEF.md
# Host Processor Memory Window Port

This block is a slave port that gives an external host processor access to an on-chip word memory. The host uses a 16-bit asynchronous bus with active-low select, read and write strobes. Two select lines choose one of four port registers: a data window, a mailbox, a memory pointer and a status word. The host writes the pointer register to set a word address. Each access to the data window then reads or writes the memory at that address and moves the pointer to the next word, so a run of data accesses covers a block of memory.

Host inputs pass through two-flop synchronisers into the system clock. A read or write takes effect on the rising edge of its strobe. The memory side is a synchronous single port with one cycle of read latency. The word at the pointer is fetched ahead of time whenever the pointer is loaded or advanced, so a data read can return it at once. A two-way mailbox connects the host and the internal processor. A word posted by the internal side raises the host interrupt until the host reads the mailbox. A word posted by the host stays pending until the internal side takes it. A status word reports both mail flags and the byte-swap setting. When byte swap is enabled, the two bytes of every data-window word are exchanged in both directions.

Top module: `host_mem_port`

## Requirements
- R1: The host select lines pick the register: 2'b00 data window, 2'b01 mailbox, 2'b10 word pointer, 2'b11 status. Reading the pointer register returns the pointer zero-extended to 16 bits.
- R2: An access takes effect only once its strobe returns high. While the strobe is held low, memory and registers keep their values.
- R3: A data-window write stores the word at the pointer and then adds one to the pointer. The pointer wraps from the last memory word to word 0.
- R4: A data-window read returns the word at the pointer and then adds one to the pointer. The next word is ready for the following read.
- R5: A word written by the internal side appears in the host mailbox register and drives hostIrq high. A host read of the mailbox clears hostIrq. If an internal write arrives in the same cycle, the set wins.
- R6: A host write to the mailbox shows the word on cpuMboxRdata and raises cpuMailPend. A cpuMboxRdEn pulse clears cpuMailPend.
- R7: The status register reads bit0 = outgoing mail pending, bit1 = incoming mail pending, bit2 = byte-swap enable. All other bits read as 0.
- R8: A host write to the status register loads the byte-swap enable from data bit 2. While it is set, data-window writes store {d[7:0],d[15:8]} and data-window reads return the stored word with its bytes exchanged.
- R9: After reset the pointer is 0, both mail flags are clear, hostIrq is low and byte swap is off.
- R10: hostDoutEn is high, and hostDout carries the selected register, only while hostCsN and hostRdN are both low. Otherwise hostDout is 0.
- R11: A strobe pulse while hostCsN is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostSel | input | 2 | Host register select |
| hostDin | input | 16 | Host write data |
| hostDout | output | 16 | Host read data |
| hostDoutEn | output | 1 | High while host read data is driven |
| hostIrq | output | 1 | Outgoing mail pending interrupt |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | AW | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after a read request |
| cpuMboxWrEn | input | 1 | Internal side posts a word to the host |
| cpuMboxWdata | input | 16 | Word posted to the host |
| cpuMboxRdEn | input | 1 | Internal side consumes the incoming word |
| cpuMboxRdata | output | 16 | Last word posted by the host |
| cpuMailPend | output | 1 | Incoming word not yet consumed |

## Verification
The assertions assume the host keeps select and write data steady for the whole time a strobe is low. They also assume each strobe stays low, and then high, for at least a few system clocks, so that the synchronised edge and the prefetch that follows complete before the next access. The bench drives every strobe low for four clocks and leaves eight clocks between accesses. It changes select and data only while the strobes are high. It pulses the internal mailbox inputs for a single cycle, on a falling clock edge and away from any host commit.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_MBOX = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_STAT = 2'b11
  } hmpSel_e;

  localparam int ST_OUT_BIT  = 0;
  localparam int ST_IN_BIT   = 1;
  localparam int ST_SWAP_BIT = 2;

  typedef struct packed {
    logic ptrLoad;
    logic ptrInc;
    logic memWrite;
    logic mboxInWr;
    logic mboxOutClr;
    logic swapLoad;
  } hmpStrb_t;
endpackage

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostCsN,
  input  logic          hostRdN,
  input  logic          hostWrN,
  input  logic [1:0]    hostSel,
  input  logic [DW-1:0] hostDin,
  output hmpStrb_t      strb,
  output logic [DW-1:0] cmdData
);
  localparam int SYNC_W = 3 + 2 + DW;

  logic [SYNC_W-1:0] syncA, syncB;
  logic csS, rdS, wrS;
  logic [1:0] selS;
  logic [DW-1:0] dinS;
  logic rdAct, wrAct, rdActD, wrActD;
  logic rdCommit, wrCommit;
  hmpSel_e selHold;
  logic [DW-1:0] dinHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= {3'b111, {(SYNC_W-3){1'b0}}};
      syncB <= {3'b111, {(SYNC_W-3){1'b0}}};
    end else begin
      syncA <= {hostCsN, hostRdN, hostWrN, hostSel, hostDin};
      syncB <= syncA;
    end
  end

  assign {csS, rdS, wrS, selS, dinS} = syncB;

  // write wins when both strobes are low
  assign wrAct = !csS && !wrS;
  assign rdAct = !csS && !rdS && wrS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActD  <= 1'b0;
      wrActD  <= 1'b0;
      selHold <= SEL_DATA;
      dinHold <= '0;
    end else begin
      rdActD <= rdAct;
      wrActD <= wrAct;
      if (rdAct || wrAct) begin
        selHold <= hmpSel_e'(selS);
        dinHold <= dinS;
      end
    end
  end

  assign rdCommit = rdActD && !rdAct;
  assign wrCommit = wrActD && !wrAct;

  always_comb begin
    strb            = '0;
    strb.ptrInc     = (rdCommit || wrCommit) && (selHold == SEL_DATA);
    strb.memWrite   = wrCommit && (selHold == SEL_DATA);
    strb.ptrLoad    = wrCommit && (selHold == SEL_ADDR);
    strb.mboxInWr   = wrCommit && (selHold == SEL_MBOX);
    strb.mboxOutClr = rdCommit && (selHold == SEL_MBOX);
    strb.swapLoad   = wrCommit && (selHold == SEL_STAT);
  end

  assign cmdData = dinHold;

  // R2: a commit is an edge event, never two in a row
  p_commit_spaced_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdCommit || wrCommit) |=> !(rdCommit || wrCommit));

  // R11: no commit unless select was low in the previous cycle
  p_cs_gates_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdCommit || wrCommit) |-> $past(!csS));
endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath
  import hmp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  hmpStrb_t      strb,
  input  logic [DW-1:0] cmdData,
  input  logic          hostCsN,
  input  logic          hostRdN,
  input  logic [1:0]    hostSel,
  output logic [DW-1:0] hostDout,
  output logic          hostDoutEn,
  output logic          hostIrq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          cpuMboxWrEn,
  input  logic [DW-1:0] cpuMboxWdata,
  input  logic          cpuMboxRdEn,
  output logic [DW-1:0] cpuMboxRdata,
  output logic          cpuMailPend
);
  localparam int HB = DW / 2;

  logic [AW-1:0] ptr;
  logic          fetchPend, rdPend;
  logic [DW-1:0] prefetchBuf;
  logic [DW-1:0] outMbox, inMbox;
  logic          outFlag, inFlag, swapEn;
  logic [DW-1:0] ptrWide, statusWord, bufView, wrView;

  function automatic logic [DW-1:0] swapBytes(input logic [DW-1:0] w);
    return {w[HB-1:0], w[DW-1:HB]};
  endfunction

  assign wrView  = swapEn ? swapBytes(cmdData) : cmdData;
  assign bufView = swapEn ? swapBytes(prefetchBuf) : prefetchBuf;

  // pointer and prefetch scheduling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      fetchPend <= 1'b1;
      rdPend    <= 1'b0;
    end else begin
      rdPend <= fetchPend && !strb.memWrite;
      if (strb.ptrLoad) begin
        ptr       <= cmdData[AW-1:0];
        fetchPend <= 1'b1;
      end else if (strb.ptrInc) begin
        ptr       <= ptr + 1'b1;
        fetchPend <= 1'b1;
      end else if (!strb.memWrite) begin
        fetchPend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prefetchBuf <= '0;
    else if (rdPend) prefetchBuf <= memRdata;
  end

  always_comb begin
    memReq   = strb.memWrite || fetchPend;
    memWe    = strb.memWrite;
    memAddr  = ptr;
    memWdata = strb.memWrite ? wrView : '0;
  end

  // mailboxes and swap control; set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMbox <= '0;
      inMbox  <= '0;
      outFlag <= 1'b0;
      inFlag  <= 1'b0;
      swapEn  <= 1'b0;
    end else begin
      if (cpuMboxWrEn) begin
        outMbox <= cpuMboxWdata;
        outFlag <= 1'b1;
      end else if (strb.mboxOutClr) begin
        outFlag <= 1'b0;
      end
      if (strb.mboxInWr) begin
        inMbox <= cmdData;
        inFlag <= 1'b1;
      end else if (cpuMboxRdEn) begin
        inFlag <= 1'b0;
      end
      if (strb.swapLoad) swapEn <= cmdData[ST_SWAP_BIT];
    end
  end

  assign hostIrq      = outFlag;
  assign cpuMboxRdata = inMbox;
  assign cpuMailPend  = inFlag;

  always_comb begin
    ptrWide = '0;
    ptrWide[AW-1:0] = ptr;
    statusWord = '0;
    statusWord[ST_OUT_BIT]  = outFlag;
    statusWord[ST_IN_BIT]   = inFlag;
    statusWord[ST_SWAP_BIT] = swapEn;
  end

  // host read path straight from the raw strobes
  always_comb begin
    hostDoutEn = !hostCsN && !hostRdN;
    hostDout   = '0;
    if (hostDoutEn) begin
      case (hmpSel_e'(hostSel))
        SEL_DATA: hostDout = bufView;
        SEL_MBOX: hostDout = outMbox;
        SEL_ADDR: hostDout = ptrWide;
        default:  hostDout = statusWord;
      endcase
    end
  end

  // R3: every memory write is followed by a pointer step
  p_write_advances_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (ptr == $past(ptr) + 1'b1));

  // R4: a read request always targets the current pointer and lands next cycle
  p_fetch_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> rdPend);

  // R5: outgoing mail raises the interrupt
  p_outmail_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuMboxWrEn |=> hostIrq);

  // R5: host mailbox read drops the interrupt
  p_outmail_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mboxOutClr && !cpuMboxWrEn) |=> !hostIrq);

  // R6: host mail marks the incoming side pending
  p_inmail_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.mboxInWr |=> (cpuMailPend && cpuMboxRdata == $past(cmdData)));

  // R10: no read data unless the read is selected
  p_dout_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsN || hostRdN) |-> (hostDout == '0));
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostCsN,
  input  logic          hostRdN,
  input  logic          hostWrN,
  input  logic [1:0]    hostSel,
  input  logic [15:0]   hostDin,
  output logic [15:0]   hostDout,
  output logic          hostDoutEn,
  output logic          hostIrq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [15:0]   memWdata,
  input  logic [15:0]   memRdata,
  input  logic          cpuMboxWrEn,
  input  logic [15:0]   cpuMboxWdata,
  input  logic          cpuMboxRdEn,
  output logic [15:0]   cpuMboxRdata,
  output logic          cpuMailPend
);
  hmpStrb_t      strb;
  logic [DW-1:0] cmdData;

  hmp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostCsN (hostCsN),
    .hostRdN (hostRdN),
    .hostWrN (hostWrN),
    .hostSel (hostSel),
    .hostDin (hostDin),
    .strb    (strb),
    .cmdData (cmdData)
  );

  hmp_datapath #(.AW(AW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cmdData      (cmdData),
    .hostCsN      (hostCsN),
    .hostRdN      (hostRdN),
    .hostSel      (hostSel),
    .hostDout     (hostDout),
    .hostDoutEn   (hostDoutEn),
    .hostIrq      (hostIrq),
    .memReq       (memReq),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memRdata     (memRdata),
    .cpuMboxWrEn  (cpuMboxWrEn),
    .cpuMboxWdata (cpuMboxWdata),
    .cpuMboxRdEn  (cpuMboxRdEn),
    .cpuMboxRdata (cpuMboxRdata),
    .cpuMailPend  (cpuMailPend)
  );
endmodule

// File: tb/host_mem_port_tb.sv
module host_mem_port_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [1:0] hostSel = 2'b00;
  logic [15:0] hostDin = '0;
  logic [15:0] hostDout;
  logic hostDoutEn, hostIrq;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic cpuMboxWrEn = 1'b0, cpuMboxRdEn = 1'b0;
  logic [15:0] cpuMboxWdata = '0;
  logic [15:0] cpuMboxRdata;
  logic cpuMailPend;

  logic [15:0] mem [DEPTH];
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  host_mem_port #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostSel(hostSel), .hostDin(hostDin),
    .hostDout(hostDout), .hostDoutEn(hostDoutEn), .hostIrq(hostIrq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .cpuMboxWrEn(cpuMboxWrEn), .cpuMboxWdata(cpuMboxWdata),
    .cpuMboxRdEn(cpuMboxRdEn), .cpuMboxRdata(cpuMboxRdata),
    .cpuMailPend(cpuMailPend)
  );

  always_ff @(posedge clk) begin
    if (memReq && memWe) mem[memAddr] <= memWdata;
    if (memReq && !memWe) memRdata <= mem[memAddr];
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    hostSel = sel; hostDin = d; hostCsN = 1'b0; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostWrN = 1'b1; hostCsN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    hostSel = sel; hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (2) @(negedge clk);
    d = hostDout;
    repeat (2) @(negedge clk);
    hostRdN = 1'b1; hostCsN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    check("R9 irq", {15'b0, hostIrq}, 16'h0000);
    check("R10 idle enable", {15'b0, hostDoutEn}, 16'h0000);
    check("R10 idle dout", hostDout, 16'h0000);
    hostRead(2'b10, v); check("R9 pointer", v, 16'h0000);
    hostRead(2'b11, v); check("R9 status", v, 16'h0000);
  endtask

  task automatic testBlockWrite();
    logic [15:0] v;
    hostWrite(2'b10, 16'h0010);
    hostRead(2'b10, v); check("R1 pointer readback", v, 16'h0010);
    // R2: strobe held low, memory untouched
    @(negedge clk);
    hostSel = 2'b00; hostDin = 16'hA1A1; hostCsN = 1'b0; hostWrN = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 held strobe", mem[8'h10], 16'h0000);
    hostWrN = 1'b1; hostCsN = 1'b1;
    repeat (8) @(negedge clk);
    check("R2 after edge", mem[8'h10], 16'hA1A1);
    hostWrite(2'b00, 16'hB2B2);
    check("R3 second word", mem[8'h11], 16'hB2B2);
    hostRead(2'b10, v); check("R3 pointer advanced", v, 16'h0012);
  endtask

  task automatic testBlockRead();
    logic [15:0] v;
    hostWrite(2'b10, 16'h0010);
    hostRead(2'b00, v); check("R4 first word", v, 16'hA1A1);
    hostRead(2'b00, v); check("R4 second word", v, 16'hB2B2);
    hostRead(2'b10, v); check("R4 pointer", v, 16'h0012);
  endtask

  task automatic testWrap();
    logic [15:0] v;
    hostWrite(2'b10, 16'h00FF);
    hostWrite(2'b00, 16'hC3C3);
    hostWrite(2'b00, 16'hD4D4);
    check("R3 last word", mem[8'hFF], 16'hC3C3);
    check("R3 wrapped word", mem[8'h00], 16'hD4D4);
    hostRead(2'b10, v); check("R3 wrapped pointer", v, 16'h0001);
  endtask

  task automatic testOutMail();
    logic [15:0] v;
    @(negedge clk); cpuMboxWdata = 16'h1234; cpuMboxWrEn = 1'b1;
    @(negedge clk); cpuMboxWrEn = 1'b0;
    check("R5 irq set", {15'b0, hostIrq}, 16'h0001);
    hostRead(2'b11, v); check("R7 status out", v, 16'h0001);
    hostRead(2'b01, v); check("R5 mailbox word", v, 16'h1234);
    check("R5 irq cleared", {15'b0, hostIrq}, 16'h0000);
  endtask

  task automatic testInMail();
    logic [15:0] v;
    hostWrite(2'b01, 16'hBEEF);
    check("R6 pending", {15'b0, cpuMailPend}, 16'h0001);
    check("R6 word", cpuMboxRdata, 16'hBEEF);
    hostRead(2'b11, v); check("R7 status in", v, 16'h0002);
    @(negedge clk); cpuMboxRdEn = 1'b1;
    @(negedge clk); cpuMboxRdEn = 1'b0;
    check("R6 consumed", {15'b0, cpuMailPend}, 16'h0000);
  endtask

  task automatic testSwap();
    logic [15:0] v;
    hostWrite(2'b11, 16'hFFFC);
    hostRead(2'b11, v); check("R7 status swap", v, 16'h0004);
    hostWrite(2'b10, 16'h0020);
    hostWrite(2'b00, 16'h1122);
    check("R8 swapped store", mem[8'h20], 16'h2211);
    hostWrite(2'b10, 16'h0020);
    hostRead(2'b00, v); check("R8 swapped read", v, 16'h1122);
    hostWrite(2'b11, 16'h0000);
    hostWrite(2'b10, 16'h0020);
    hostRead(2'b00, v); check("R8 plain read", v, 16'h2211);
  endtask

  task automatic testCsHigh();
    logic [15:0] v;
    hostWrite(2'b10, 16'h0030);
    @(negedge clk);
    hostSel = 2'b00; hostDin = 16'h5A5A; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostWrN = 1'b1;
    repeat (8) @(negedge clk);
    check("R11 memory untouched", mem[8'h30], 16'h0000);
    hostRead(2'b10, v); check("R11 pointer unchanged", v, 16'h0030);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testBlockWrite();
    testBlockRead();
    testWrap();
    testOutMail();
    testInMail();
    testSwap();
    testCsHigh();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule